// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Target

This block is the bus-facing front end of a small peripheral that is reached over a two-wire serial bus (I2C). It samples the clock and data lines with the system clock and recognises start, repeated start and stop conditions. It compares the first byte of each transfer against a 7-bit address. The address is the constant nibble `0100` followed by three strap inputs.

When the address matches, the block acknowledges the byte. In a write, the next byte is a command that sets a register pointer. Every further byte in that write goes to the pointed register through a write strobe and a data bus.

A read is done by a repeated start with the read bit set. The block then fetches data from the pointed register through a read strobe and shifts it out MSB first. It keeps doing so until the controller answers with a not-acknowledge. The pointer never advances on its own. The four registers are held outside this block: an input port (index 0, read-only), an output port (1), polarity (2) and direction (3).

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset the pointer (`regSel`) is 0, `sdaDriveLow` is 0 and neither strobe is asserted.
- R2: An address byte whose upper seven bits equal binary 0100 followed by `strapAddr[2:0]` is acknowledged (SDA pulled low during the ninth clock). Any other address is not acknowledged, and the following bytes are ignored until the next start condition.
- R3: The first byte after a write address is the command byte. It is always acknowledged and loads the pointer with its low two bits, so commands 4 to 7 alias to 0 to 3.
- R4: Each acknowledged data byte of a write to pointer 1, 2 or 3 produces exactly one `regWrStb` pulse, with `regSel` equal to the pointer and `regWrData` equal to the byte.
- R5: Consecutive data bytes in one write all go to the same register; the pointer does not change.
- R6: A data byte written while the pointer is 0 is acknowledged but produces no write strobe.
- R7: After an address byte with the read bit (LSB = 1), the block returns the pointed register's value MSB first. It pulses `regRdStb` once per byte and sends another byte after a controller ACK. It releases SDA for good after a NACK.
- R8: A read that carries no command byte returns the register selected by the last command byte, including a read of the live input value at pointer 0.
- R9: The block changes its SDA drive only while SCL is low. It never drives SDA during the acknowledge clock of a byte it transmits.
- R10: A stop condition in the middle of a byte returns the block to idle, with SDA released and no write strobe. A later start condition begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapAddr | input | 3 | Low three address bits |
| sdaDriveLow | output | 1 | 1 = pull the data line low (open-drain enable) |
| regSel | output | 2 | Register pointer / index for both strobes |
| regWrStb | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Data accompanying `regWrStb` |
| regRdStb | output | 1 | One-cycle read strobe; `regRdData` is captured in that cycle |
| regRdData | input | 8 | Contents of the register at `regSel` |

## Verification
The bench sweeps all eight strap values against every address sharing the fixed nibble and against near misses. A wrong comparison shows up as an acknowledge on the wrong address or a missing one.

It walks all eight command values with a write followed by a repeated-start read. A design that used more pointer bits, or that let index 0 be written, would strobe the wrong register or return changed input data.

Multi-byte writes and reads catch a pointer that advances. A stop inside a data byte catches a design that emits a partial write. A line monitor flags any change of the SDA drive while SCL is high, which is the mark of a drive that is timed off the wrong clock edge.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture sdaBit into the receive shifter
    logic sdaBit;    // synchronised data line level
    logic ptrLoad;   // command byte complete: load pointer
    logic wrReq;     // data byte complete: request a register write
    logic txLoad;    // fetch a register value for transmission
    logic txShift;   // advance to next transmit bit
    logic ackDrive;  // hold SDA low for an acknowledge
    logic txDrive;   // transmit shifter owns SDA
  } strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } phase_t;

endpackage

// File: rtl/i2c_ptr_ctrl.sv
module i2c_ptr_ctrl
  import i2c_ptr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BITS        = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     addrHit,
  input  logic     rwBit,
  output strobes_t strb
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;

  busState_t       stQ, stN;
  phase_t          phQ, phN;
  logic [CNT_W-1:0] cntQ, cntN;
  logic            rwQ, rwN;
  logic            ackSeenQ, ackSeenN;

  always_comb begin
    stN      = stQ;
    phN      = phQ;
    cntN     = cntQ;
    rwN      = rwQ;
    ackSeenN = ackSeenQ;
    strb          = '0;
    strb.sdaBit   = sdaS;
    strb.ackDrive = (stQ == ST_ACK);
    strb.txDrive  = (stQ == ST_TX);
    if (startEv) begin
      stN  = ST_RX;
      phN  = PH_ADDR;
      cntN = '0;
    end else if (stopEv) begin
      stN = ST_IDLE;
    end else begin
      case (stQ)
        ST_RX: begin
          if (sclRise && cntQ != FULL) begin
            strb.shiftIn = 1'b1;
            cntN = cntQ + 1'b1;
          end else if (sclFall && cntQ == FULL) begin
            case (phQ)
              PH_ADDR: begin
                if (addrHit) begin
                  stN = ST_ACK;
                  rwN = rwBit;
                end else begin
                  stN = ST_IDLE;
                end
              end
              PH_CMD: begin
                strb.ptrLoad = 1'b1;
                stN = ST_ACK;
                phN = PH_DATA;
              end
              default: begin
                strb.wrReq = 1'b1;
                stN = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntN = '0;
            if (phQ == PH_ADDR && rwQ) begin
              strb.txLoad = 1'b1;
              stN = ST_TX;
            end else begin
              stN = ST_RX;
              if (phQ == PH_ADDR) phN = PH_CMD;
            end
          end
        end
        ST_TX: begin
          if (sclRise && cntQ != FULL) begin
            cntN = cntQ + 1'b1;
          end else if (sclFall) begin
            if (cntQ == FULL) stN = ST_TXACK;
            else              strb.txShift = 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            ackSeenN = ~sdaS;
          end else if (sclFall) begin
            if (ackSeenQ) begin
              strb.txLoad = 1'b1;
              stN  = ST_TX;
              cntN = '0;
            end else begin
              stN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      phQ      <= PH_ADDR;
      cntQ     <= '0;
      rwQ      <= 1'b0;
      ackSeenQ <= 1'b0;
    end else begin
      stQ      <= stN;
      phQ      <= phN;
      cntQ     <= cntN;
      rwQ      <= rwN;
      ackSeenQ <= ackSeenN;
    end
  end

  // R2: bit counter never runs past a full byte
  assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL);

  // R2: an address acknowledge only follows a matching address byte
  assert_ack_needs_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_ACK && $past(stQ) == ST_RX && phQ == PH_ADDR) |-> $past(addrHit));

  // R9: SDA ownership switches only from a cycle with SCL low
  assert_drive_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((!$stable(strb.ackDrive) || !$stable(strb.txDrive)) &&
     !$past(startEv) && !$past(stopEv)) |-> !$past(sclS));

endmodule

// File: rtl/i2c_ptr_dp.sv
module i2c_ptr_dp
  import i2c_ptr_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          REG_CNT = 4,
  parameter int          HI_W    = 4,
  parameter int          STRAP_W = 3,
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic [STRAP_W-1:0]         strapAddr,
  input  logic [DATA_W-1:0]          regRdData,
  output logic                       addrHit,
  output logic                       rwBit,
  output logic                       sdaDriveLow,
  output logic [$clog2(REG_CNT)-1:0] regSel,
  output logic                       regWrStb,
  output logic                       regRdStb,
  output logic [DATA_W-1:0]          regWrData
);

  localparam int PTR_W = $clog2(REG_CNT);

  logic [DATA_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptrQ    <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], strb.sdaBit};
      if (strb.ptrLoad) ptrQ <= rxShift[PTR_W-1:0];
      if (strb.txLoad)       txShift <= regRdData;
      else if (strb.txShift) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign addrHit     = (rxShift[DATA_W-1:1] == {ADDR_HI, strapAddr});
  assign rwBit       = rxShift[0];
  assign regSel      = ptrQ;
  assign regWrData   = rxShift;
  assign regWrStb    = strb.wrReq & (ptrQ != '0);
  assign regRdStb    = strb.txLoad;
  assign sdaDriveLow = strb.ackDrive | (strb.txDrive & ~txShift[DATA_W-1]);

  // R3: a command byte lands its low bits in the pointer
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |=> regSel == $past(rxShift[PTR_W-1:0]));

  // R5: without a command byte the pointer stays put
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ptrLoad |=> $stable(regSel));

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              DATA_W      = 8,
  parameter int              REG_CNT     = 4,
  parameter int              STRAP_W     = 3,
  parameter logic [3:0]      ADDR_HI     = 4'b0100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic [STRAP_W-1:0]         strapAddr,
  output logic                       sdaDriveLow,
  output logic [$clog2(REG_CNT)-1:0] regSel,
  output logic                       regWrStb,
  output logic [DATA_W-1:0]          regWrData,
  output logic                       regRdStb,
  input  logic [DATA_W-1:0]          regRdData
);

  strobes_t strb;
  logic     addrHit, rwBit;

  i2c_ptr_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .BITS       (DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .addrHit(addrHit),
    .rwBit  (rwBit),
    .strb   (strb)
  );

  i2c_ptr_dp #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT),
    .HI_W   (4),
    .STRAP_W(STRAP_W),
    .ADDR_HI(ADDR_HI)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .strapAddr  (strapAddr),
    .regRdData  (regRdData),
    .addrHit    (addrHit),
    .rwBit      (rwBit),
    .sdaDriveLow(sdaDriveLow),
    .regSel     (regSel),
    .regWrStb   (regWrStb),
    .regRdStb   (regRdStb),
    .regWrData  (regWrData)
  );

  // R4: a cycle never carries both a write and a read strobe
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrStb, regRdStb}));

endmodule

// File: tb/i2c_ptr_target_tb.sv
module i2c_ptr_target_tb;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [2:0] strap = 3'd0;
  logic sdaDriveLow, regWrStb, regRdStb;
  logic [1:0] regSel;
  logic [7:0] regWrData, regRdData;
  logic sdaLine;
  logic [7:0] bank [4];
  logic [7:0] expBank [4];
  logic [7:0] inPort = 8'h00;

  int checks = 0, failures = 0;
  int wrCnt = 0, rdCnt = 0, r9Viol = 0;
  logic [1:0] lastWrSel = 2'd0;
  logic [7:0] lastWrData = 8'h00;
  logic prevDrive = 1'b0, sclPrev = 1'b1;
  bit done = 0;

  always #10 clk = ~clk;

  assign sdaLine   = sdaDrv & ~sdaDriveLow;
  assign regRdData = (regSel == 2'd0) ? inPort : bank[regSel];

  i2c_ptr_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .strapAddr(strap),
    .sdaDriveLow(sdaDriveLow), .regSel(regSel), .regWrStb(regWrStb),
    .regWrData(regWrData), .regRdStb(regRdStb), .regRdData(regRdData)
  );

  always @(posedge clk) begin
    if (regWrStb) begin
      bank[regSel] <= regWrData;
      wrCnt <= wrCnt + 1;
      lastWrSel <= regSel;
      lastWrData <= regWrData;
    end
    if (regRdStb) rdCnt <= rdCnt + 1;
    if (rstN && sclDrv && sclPrev && sdaDriveLow != prevDrive) r9Viol <= r9Viol + 1;
    prevDrive <= sdaDriveLow;
    sclPrev <= sclDrv;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b, output logic s);
    sdaDrv = b; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    s = sdaLine; waitClk(Q);
    sclDrv = 1'b0; waitClk(Q);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b1; waitClk(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(v[i], s);
    clkBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      v[i] = s;
    end
    clkBit(~masterAck, s);
  endtask

  function automatic logic [7:0] expVal(input logic [1:0] p);
    return (p == 2'd0) ? inPort : expBank[p];
  endfunction

  function automatic logic [7:0] addrByte(input logic [2:0] s, input logic rd);
    return {4'b0100, s, rd};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int w0, r0;
    for (int i = 0; i < 4; i++) begin bank[i] = 8'h00; expBank[i] = 8'h00; end
    waitClk(5);
    // R1 reset state
    check(sdaDriveLow == 1'b0, "R1 sda", sdaDriveLow, 0);
    check(regSel == 2'd0, "R1 ptr", regSel, 0);
    check(!regWrStb && !regRdStb, "R1 strobes", {regWrStb, regRdStb}, 0);
    rstN = 1'b1;
    waitClk(5);
    check(regSel == 2'd0 && sdaDriveLow == 1'b0, "R1 after release", regSel, 0);

    // R2 address sweep over straps
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 10; a++) begin
        logic [6:0] ad;
        if (a < 8) ad = {4'b0100, 3'(a)};
        else if (a == 8) ad = {4'b0101, 3'(s)};
        else ad = {4'b1100, 3'(s)};
        busStart();
        writeByte({ad, 1'b0}, ack);
        busStop();
        check(ack == (ad == {4'b0100, 3'(s)}), "R2 addr match", ack, (ad == {4'b0100, 3'(s)}));
      end
    end
    strap = 3'd5;
    check(wrCnt == 0 && regSel == 2'd0, "R2 no side effect", wrCnt, 0);

    // R3 R4 R6 R7 command sweep, write then repeated-start read
    for (int c = 0; c < 8; c++) begin
      logic [7:0] d;
      d = 8'(c * 37 + 5);
      inPort = 8'(8'hA0 + c);
      w0 = wrCnt;
      busStart();
      writeByte(addrByte(strap, 1'b0), ack);
      writeByte(8'(c), ack);
      check(ack, "R3 cmd ack", ack, 1);
      check(regSel == 2'(c), "R3 ptr low bits", regSel, c % 4);
      writeByte(d, ack);
      check(ack, "R4 data ack", ack, 1);
      if ((c % 4) != 0) begin
        expBank[c % 4] = d;
        check(wrCnt == w0 + 1 && lastWrSel == 2'(c) && lastWrData == d, "R4 write strobe",
              lastWrData, d);
      end else begin
        check(wrCnt == w0, "R6 read-only write ignored", wrCnt - w0, 0);
      end
      r0 = rdCnt;
      busStart();
      writeByte(addrByte(strap, 1'b1), ack);
      check(ack, "R7 read addr ack", ack, 1);
      readByte(1'b0, v);
      busStop();
      check(v == expVal(2'(c)), "R7 readback", v, expVal(2'(c)));
      check(rdCnt == r0 + 1, "R7 one read strobe", rdCnt - r0, 1);
    end

    // R5 several bytes to one register
    w0 = wrCnt;
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    writeByte(8'd2, ack);
    writeByte(8'h11, ack);
    writeByte(8'h22, ack);
    writeByte(8'h33, ack);
    busStop();
    expBank[2] = 8'h33;
    check(wrCnt == w0 + 3, "R5 three strobes", wrCnt - w0, 3);
    check(lastWrSel == 2'd2 && lastWrData == 8'h33, "R5 same register", lastWrSel, 2);
    check(regSel == 2'd2, "R5 ptr unchanged", regSel, 2);

    // R7 multi-byte read ending in NACK
    r0 = rdCnt;
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    writeByte(8'd1, ack);
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, v);
      check(v == expBank[1], "R7 multi read", v, expBank[1]);
    end
    check(sdaDriveLow == 1'b0, "R7 released after nack", sdaDriveLow, 0);
    check(rdCnt == r0 + 3, "R7 read strobes", rdCnt - r0, 3);
    busStop();

    // R8 read without a command byte
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    readByte(1'b0, v);
    busStop();
    check(v == expBank[1], "R8 last pointer", v, expBank[1]);
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    writeByte(8'd0, ack);
    busStop();
    inPort = 8'hC3;
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    readByte(1'b0, v);
    busStop();
    check(v == 8'hC3, "R8 input live", v, 8'hC3);
    inPort = 8'h5A;
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    readByte(1'b0, v);
    busStop();
    check(v == 8'h5A, "R8 input live again", v, 8'h5A);

    // R10 stop inside a data byte
    w0 = wrCnt;
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    writeByte(8'd2, ack);
    begin
      logic s;
      for (int i = 0; i < 4; i++) clkBit(1'b0, s);
    end
    busStop();
    waitClk(Q);
    check(wrCnt == w0, "R10 no partial write", wrCnt - w0, 0);
    check(sdaDriveLow == 1'b0, "R10 released", sdaDriveLow, 0);
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    readByte(1'b0, v);
    busStop();
    check(ack && v == expBank[2], "R10 new transfer", v, expBank[2]);

    // R2 unmatched address then bytes ignored
    w0 = wrCnt;
    busStart();
    writeByte(addrByte(3'd2, 1'b0), ack);
    check(!ack, "R2 no ack other address", ack, 0);
    writeByte(8'd3, ack);
    check(!ack, "R2 later byte ignored", ack, 0);
    writeByte(8'hAA, ack);
    busStop();
    check(wrCnt == w0 && regSel == 2'd2, "R2 ignored bytes", regSel, 2);

    // R9 drive changes only with SCL low
    check(r9Viol == 0, "R9 sda timing", r9Viol, 0);

    finishRun();
  end

endmodule